// File: doc/BRIEF.md
# Two-Wire Bus Recovery Sequencer

This block sits on the master side of a two-wire serial bus. It brings a slave memory back into step when the slave may still be partway through a transfer. A typical cause is a supply dip that reset the master and left the slave untouched. The slave has no reset pin, so the only way to clear it is through the bus itself.

When started, the block drives both open-drain lines through a fixed pattern:

1. A first start condition.
2. Nine dummy SCL pulses with SDA released, so that a slave pulling SDA low for a zero bit or an acknowledge gives up that output.
3. A second start condition, placed directly after the ninth pulse, which resets the slave's internal state.
4. A stop condition, after which normal traffic may resume.

The sequence runs once by itself after reset when the auto-start parameter is set, and again each time the trigger input is pulsed while the block is idle. The bus timing unit is a quarter period of `divSetting` system clocks. The value is captured when a sequence begins.

Top module: `busRecovery`

## Requirements
- R1: While reset is applied and whenever `busy` is low, both lines are released (`sclHoldLow` = 0, `sdaHoldLow` = 0, where 1 means pull the line low) and `done` is low.
- R2: The sequence opens with a start condition: SDA falls while SCL is released, with no SCL edge before it and both lines released for at least one quarter period beforehand.
- R3: Between the first and second start, SCL completes exactly nine high pulses (rise followed by fall), and SDA is released at every SCL rising edge.
- R4: After the ninth pulse, SCL rises once and stays high until the second start, so exactly ten SCL rising edges occur between the two starts.
- R5: After the second start, SDA rises while SCL stays high (a stop) with no SCL edge in between. Each sequence has exactly two starts and one stop, and both lines end released.
- R6: SCL and SDA never change in the same clock cycle, and consecutive line changes are at least Q system clocks apart. Q is the captured `divSetting`, with 0 treated as 1.
- R7: `busy` stays high for exactly 45·Q cycles. The breakdown is:
  - 1 quarter of idle-level setup;
  - 1 quarter after the SDA fall;
  - 1 quarter after the SCL fall;
  - 1 quarter after the SDA release;
  - 2 high and 2 low quarters for each dummy pulse;
  - 2 quarters for the final SCL rise;
  - 2 quarters holding the second start;
  - 1 quarter after the stop.
- R8: `done` is a single-cycle pulse that occurs in the first cycle in which `busy` is low after a sequence, and at no other time.
- R9: A trigger that arrives while `busy` is high is ignored: it neither restarts nor queues a sequence. A change of `divSetting` while busy does not alter the running sequence's timing.
- R10: With `AUTO_START` = 1, a sequence begins by itself after reset is released and does not repeat until a trigger arrives.
- R11: A `divSetting` of 0 behaves as 1, giving a 45-cycle sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| trigger | input | 1 | Starts a sequence when sampled high while idle |
| divSetting | input | DIV_W | Quarter bus period in system clocks (0 acts as 1) |
| sclHoldLow | output | 1 | 1 pulls SCL low, 0 releases it |
| sdaHoldLow | output | 1 | 1 pulls SDA low, 0 releases it |
| busy | output | 1 | High while a sequence is running |
| done | output | 1 | One-cycle pulse when a sequence ends |

## Verification
The hardest cases to reach from the ports are a trigger arriving, and `divSetting` changing, in the middle of a running sequence. Both are only meaningful while the dummy clocks are under way. The bench therefore waits a fixed number of quarter periods after starting a run, then pulses the trigger and writes a new divider value. It then checks that the busy length, the edge spacing and the single `done` still follow the divider value captured at the start. A line monitor rebuilds starts, stops and SCL pulses from the sampled pin levels. This exposes any extra pulse between the ninth dummy clock and the second start, which would otherwise look like a normal clock.

// File: rtl/recovery_pkg.sv
package recovery_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_SETUP,
    ST_START1,
    ST_SCLDOWN,
    ST_SDAFREE,
    ST_CLKHI,
    ST_CLKLO,
    ST_RISE2,
    ST_START2,
    ST_STOP
  } recState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic       seqBegin;
    logic       stepLoad;
    logic [1:0] stepQuarters;
    logic       pulseClear;
    logic       pulseInc;
    logic       sclLowNext;
    logic       sdaLowNext;
  } recStrobe_t;

  // quarter periods spent in each state
  function automatic logic [1:0] quartersOf(recState_t s);
    case (s)
      ST_CLKHI, ST_CLKLO, ST_RISE2, ST_START2: quartersOf = 2'd2;
      ST_IDLE:                                 quartersOf = 2'd0;
      default:                                 quartersOf = 2'd1;
    endcase
  endfunction

  // {scl pulled low, sda pulled low} for each state
  function automatic logic [1:0] levelsOf(recState_t s);
    case (s)
      ST_START1:  levelsOf = 2'b01;
      ST_SCLDOWN: levelsOf = 2'b11;
      ST_SDAFREE: levelsOf = 2'b10;
      ST_CLKLO:   levelsOf = 2'b10;
      ST_START2:  levelsOf = 2'b01;
      default:    levelsOf = 2'b00;
    endcase
  endfunction

  // successor once the current state's time has run out
  function automatic recState_t successorOf(recState_t s, logic lastPulse);
    case (s)
      ST_SETUP:   successorOf = ST_START1;
      ST_START1:  successorOf = ST_SCLDOWN;
      ST_SCLDOWN: successorOf = ST_SDAFREE;
      ST_SDAFREE: successorOf = ST_CLKHI;
      ST_CLKHI:   successorOf = ST_CLKLO;
      ST_CLKLO:   successorOf = lastPulse ? ST_RISE2 : ST_CLKHI;
      ST_RISE2:   successorOf = ST_START2;
      ST_START2:  successorOf = ST_STOP;
      default:    successorOf = ST_IDLE;
    endcase
  endfunction

endpackage

// File: rtl/recoveryDatapath.sv
module recoveryDatapath
  import recovery_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int DUMMY_PULSES = 9
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divSetting,
  input  recStrobe_t       strb,
  output logic             stepDone,
  output logic             lastPulse,
  output logic             sclLow,
  output logic             sdaLow
);

  localparam int CNT_W   = DIV_W + 2;
  localparam int PULSE_W = $clog2(DUMMY_PULSES + 1);

  logic [DIV_W-1:0]   divQ;
  logic [DIV_W-1:0]   divIn;
  logic [DIV_W-1:0]   effDiv;
  logic [CNT_W-1:0]   stepCnt;
  logic [CNT_W-1:0]   stepLen;
  logic [PULSE_W-1:0] pulseCnt;

  // zero divider acts as one
  assign divIn  = (divSetting == '0) ? DIV_W'(1) : divSetting;
  assign effDiv = strb.seqBegin ? divIn : divQ;
  assign stepLen = CNT_W'(strb.stepQuarters) * CNT_W'(effDiv);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) divQ <= DIV_W'(1);
    else if (strb.seqBegin) divQ <= divIn;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stepCnt <= '0;
    else if (strb.stepLoad) stepCnt <= stepLen - CNT_W'(1);
    else if (stepCnt != '0) stepCnt <= stepCnt - CNT_W'(1);
  end

  assign stepDone = (stepCnt == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pulseCnt <= '0;
    else if (strb.pulseClear) pulseCnt <= '0;
    else if (strb.pulseInc) pulseCnt <= pulseCnt + PULSE_W'(1);
  end

  assign lastPulse = (pulseCnt == PULSE_W'(DUMMY_PULSES - 1));

  // registered pin drivers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sclLow <= 1'b0;
      sdaLow <= 1'b0;
    end else begin
      sclLow <= strb.sclLowNext;
      sdaLow <= strb.sdaLowNext;
    end
  end

endmodule

// File: rtl/recoveryControl.sv
module recoveryControl
  import recovery_pkg::*;
#(
  parameter bit AUTO_START = 1'b1
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       trigger,
  input  logic       stepDone,
  input  logic       lastPulse,
  output recStrobe_t strb,
  output logic       busy,
  output logic       done
);

  recState_t state;
  recState_t nextState;
  logic      autoPending;
  logic      launch;
  logic [1:0] nextLevels;

  assign launch = (state == ST_IDLE) && (trigger || autoPending);

  always_comb begin
    nextState = state;
    if (state == ST_IDLE) begin
      if (launch) nextState = ST_SETUP;
    end else if (stepDone) begin
      nextState = successorOf(state, lastPulse);
    end
  end

  assign nextLevels = levelsOf(nextState);

  always_comb begin
    strb              = '0;
    strb.seqBegin     = launch;
    strb.pulseClear   = launch;
    strb.pulseInc     = (state == ST_CLKLO) && stepDone;
    strb.stepLoad     = (nextState != state) && (nextState != ST_IDLE);
    strb.stepQuarters = quartersOf(nextState);
    strb.sclLowNext   = nextLevels[1];
    strb.sdaLowNext   = nextLevels[0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else state <= nextState;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) autoPending <= AUTO_START;
    else if (launch) autoPending <= 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) done <= 1'b0;
    else done <= (state == ST_STOP) && stepDone;
  end

  assign busy = (state != ST_IDLE);

endmodule

// File: rtl/busRecovery.sv
module busRecovery
  import recovery_pkg::*;
#(
  parameter int DIV_W        = 8,
  parameter int DUMMY_PULSES = 9,
  parameter bit AUTO_START   = 1'b1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             trigger,
  input  logic [DIV_W-1:0] divSetting,
  output logic             sclHoldLow,
  output logic             sdaHoldLow,
  output logic             busy,
  output logic             done
);

  recStrobe_t strb;
  logic       stepDone;
  logic       lastPulse;

  recoveryControl #(.AUTO_START(AUTO_START)) uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .trigger  (trigger),
    .stepDone (stepDone),
    .lastPulse(lastPulse),
    .strb     (strb),
    .busy     (busy),
    .done     (done)
  );

  recoveryDatapath #(.DIV_W(DIV_W), .DUMMY_PULSES(DUMMY_PULSES)) uPath (
    .clk       (clk),
    .rstN      (rstN),
    .divSetting(divSetting),
    .strb      (strb),
    .stepDone  (stepDone),
    .lastPulse (lastPulse),
    .sclLow    (sclHoldLow),
    .sdaLow    (sdaHoldLow)
  );

endmodule

// File: rtl/busRecoveryChecker.sv
module busRecoveryChecker (
  input logic clk,
  input logic rstN,
  input logic sclHoldLow,
  input logic sdaHoldLow,
  input logic busy,
  input logic done
);

  assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!sclHoldLow && !sdaHoldLow));

  // SDA is only pulled low while SCL is released (start conditions)
  assert_start_with_scl_high_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaHoldLow) |-> !sclHoldLow);

  // every SCL rise finds SDA released
  assert_sda_free_at_rise_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclHoldLow) |-> !sdaHoldLow);

  assert_single_line_change_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(!$stable(sclHoldLow) && !$stable(sdaHoldLow)));

  assert_done_one_cycle_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_at_end_R8: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  assert_end_flags_done_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

endmodule

bind busRecovery busRecoveryChecker uChk (
  .clk       (clk),
  .rstN      (rstN),
  .sclHoldLow(sclHoldLow),
  .sdaHoldLow(sdaHoldLow),
  .busy      (busy),
  .done      (done)
);

// File: tb/tb_busRecovery.sv
module tb_busRecovery;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             trigger = 1'b0;
  logic [DIV_W-1:0] divSetting = '0;
  logic             sclHoldLow, sdaHoldLow, busy, done;

  int total = 0;
  int bad = 0;

  busRecovery #(.DIV_W(DIV_W), .DUMMY_PULSES(9), .AUTO_START(1'b1)) dut (
    .clk(clk), .rstN(rstN), .trigger(trigger), .divSetting(divSetting),
    .sclHoldLow(sclHoldLow), .sdaHoldLow(sdaHoldLow), .busy(busy), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- line monitor ----------------
  int runId = 0, seenRun = 0, monQ = 1;
  int startCnt, stopCnt, preEdges, risesBetween, pulses, sdaLowAtRise;
  int risesAtStart2, pulsesAtStart2, postEdges, simul, gapBad, sinceChange;
  int busyCycles, doneCnt, doneWide;
  bit riseSeen, haveChange;
  bit prevScl = 1'b1, prevSda = 1'b1, prevDone = 1'b0;

  always @(negedge clk) begin
    bit sclH, sdaH, sclChg, sdaChg;
    if (runId != seenRun) begin
      seenRun = runId;
      startCnt = 0; stopCnt = 0; preEdges = 0; risesBetween = 0; pulses = 0;
      sdaLowAtRise = 0; risesAtStart2 = -1; pulsesAtStart2 = -1; postEdges = 0;
      simul = 0; gapBad = 0; sinceChange = 0; busyCycles = 0; doneCnt = 0;
      doneWide = 0; riseSeen = 0; haveChange = 0;
    end
    sclH = !sclHoldLow;
    sdaH = !sdaHoldLow;
    if (rstN) begin
      sclChg = (sclH != prevScl);
      sdaChg = (sdaH != prevSda);
      if (busy) busyCycles++;
      if (done) doneCnt++;
      if (done && prevDone) doneWide++;
      if (sclChg && sdaChg) simul++;
      if (sclChg || sdaChg) begin
        if (haveChange && (sinceChange + 1) < monQ) gapBad++;
        sinceChange = 0;
        haveChange = 1;
      end else begin
        sinceChange++;
      end
      if (sclChg) begin
        if (startCnt == 0) preEdges++;
        else if (startCnt == 1) begin
          if (sclH) begin
            risesBetween++;
            riseSeen = 1;
            if (!sdaH) sdaLowAtRise++;
          end else if (riseSeen) begin
            pulses++;
            riseSeen = 0;
          end
        end else if (stopCnt == 0) postEdges++;
      end
      if (sdaChg && !sclChg && sclH) begin
        if (!sdaH) begin
          if (startCnt == 1) begin
            risesAtStart2 = risesBetween;
            pulsesAtStart2 = pulses;
          end
          startCnt++;
        end else begin
          stopCnt++;
        end
      end
    end
    prevScl = sclH;
    prevSda = sdaH;
    prevDone = done;
  end

  // ---------------- checking helpers ----------------
  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int quarterOf(input int d);
    return (d == 0) ? 1 : d;
  endfunction

  function automatic int expectedBusy(input int q);
    // setup 1 + start 1 + scl fall 1 + sda free 1 + 9*(2+2) + rise 2 + start2 2 + stop 1
    return q * (4 + 9 * 4 + 2 + 2 + 1);
  endfunction

  task automatic waitDone(input int q);
    int limit = expectedBusy(q) + 200;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (doneCnt > 0) break;
    end
    repeat (4 * q + 6) @(negedge clk);
  endtask

  task automatic verifyRun(input int q, input string tag);
    check(startCnt >= 1 && preEdges == 0, {"R2 first event is a start ", tag}, preEdges, 0);
    check(pulsesAtStart2 == 9, {"R3 dummy pulses ", tag}, pulsesAtStart2, 9);
    check(sdaLowAtRise == 0, {"R3 sda released at rises ", tag}, sdaLowAtRise, 0);
    check(risesAtStart2 == 10, {"R4 scl rises between starts ", tag}, risesAtStart2, 10);
    check(startCnt == 2, {"R5 start count ", tag}, startCnt, 2);
    check(stopCnt == 1 && postEdges == 0, {"R5 stop with scl steady ", tag}, stopCnt*10 + postEdges, 10);
    check(!sclHoldLow && !sdaHoldLow && !busy, {"R1 released after run ", tag},
          {sclHoldLow, sdaHoldLow, busy}, 0);
    check(simul == 0 && gapBad == 0, {"R6 edge spacing ", tag}, simul*100 + gapBad, 0);
    check(busyCycles == expectedBusy(q), {"R7 busy length ", tag}, busyCycles, expectedBusy(q));
    check(doneCnt == 1 && doneWide == 0, {"R8 done pulse ", tag}, doneCnt*10 + doneWide, 10);
  endtask

  task automatic runOnce(input int d, input bit disturb, input string tag);
    int q = quarterOf(d);
    divSetting = DIV_W'(d);
    monQ = q;
    runId++;
    @(negedge clk);
    trigger = 1'b1;
    @(negedge clk);
    trigger = 1'b0;
    if (disturb) begin
      repeat (10 * q) @(negedge clk);
      trigger = 1'b1;                    // R9: ignored while busy
      divSetting = DIV_W'(d + 3);
      @(negedge clk);
      trigger = 1'b0;
    end
    waitDone(q);
    verifyRun(q, tag);
    if (disturb)
      check(!busy && doneCnt == 1, {"R9 busy trigger ignored ", tag}, doneCnt, 1);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  // ---------------- stimulus ----------------
  initial begin
    int seed;
    seed = $urandom(32'd24680);
    divSetting = DIV_W'(3);
    monQ = 3;
    runId = 1;
    repeat (5) @(negedge clk);
    check(!sclHoldLow && !sdaHoldLow && !busy && !done, "R1 reset state",
          {sclHoldLow, sdaHoldLow, busy, done}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 1'b1, "R10 auto start after reset", busy, 1);
    waitDone(3);
    verifyRun(3, "auto");
    repeat (200) @(negedge clk);
    check(!busy && doneCnt == 1, "R10 no repeat without trigger", doneCnt, 1);

    runOnce(0, 1'b0, "div0");
    check(busyCycles == 45, "R11 zero divider acts as one", busyCycles, 45);
    runOnce(1, 1'b0, "div1");
    runOnce(255, 1'b0, "divmax");
    runOnce(4, 1'b1, "disturbed");

    for (int i = 0; i < 8; i++) begin
      int d = $urandom_range(20, 1);
      runOnce(d, (i % 3) == 0, "random");
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule